// File: doc/BRIEF.md
# PHY Reset and Power-Down Sequencer

This block sequences reset and power-down for the physical layer of a serial bus. It samples an active-low reset pin and an active-high power-down input on a free-running reference clock. It measures how long each input stays asserted. From these measurements it drives five things: the internal reset of the physical layer, the enable of its system clock, a one-cycle bus-reset request to each active cable port, the enable of the powered domain, and a flag that shows whether the long reset width still applies.

There are two minimum reset widths. The long width applies after power-on and after a valid power-down. The short width applies during normal operation. A low pulse on the reset pin that is shorter than the width that applies is ignored. A pulse that meets the width puts the block into its reset-start state. When the pin then goes high, the internal reset releases and a bus reset is sent on every active cable port. Power-down forces the internal reset and removes power from everything except cable-not-active detection, which is outside this block and keeps running. A power-down counts as valid only if it is held for a minimum time. All thresholds are parameters given in reference clock cycles.

Top module: `phy_rst_pwr_seq`

## Requirements
- R1: While the power-on reset is active, and until it has been synchronously released, the outputs are held at these values: int_rst=1, sysclk_en=0, bus_rst_req=0, pwr_en=1, long_pend=1.
- R2: While long_pend=1, the reset pin has to be sampled low on at least LONG_CYC consecutive cycles, with pwr_dn low. After that, the first cycle the pin is sampled high clears int_rst on that same edge. A pulse of LONG_CYC-1 cycles leaves int_rst at 1.
- R3: While long_pend=0, int_rst rises on the edge that samples the SHORT_CYC-th consecutive low of the reset pin. It clears on the first edge after that where the pin is sampled high. A pulse of SHORT_CYC-1 cycles changes no output.
- R4: On the edge that releases int_rst, bit i of bus_rst_req rises if and only if port_active[i] was 1 at that edge. It falls on the next edge. No other event raises bus_rst_req.
- R5: sysclk_en is 0 whenever int_rst is 1. It rises one clock after int_rst falls.
- R6: Each edge that samples pwr_dn=1 sets int_rst=1, whatever the reset pin does.
- R7: On every edge, pwr_en takes the inverse of the pwr_dn value sampled on that edge.
- R8: long_pend sets on the edge that samples the PD_CYC-th consecutive high of pwr_dn. A shorter power-down leaves it unchanged.
- R9: long_pend clears on the same edge that releases int_rst.
- R10: Low cycles of the reset pin that are sampled while pwr_dn=1 do not count toward the reset width. Counting starts again once pwr_dn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Reset pin level, active low, synchronous to clk |
| pwr_dn | input | 1 | Power-down request, active high |
| port_active | input | NPORTS | One bit per cable port, 1 when the port is active |
| int_rst | output | 1 | Internal reset of the physical layer, active high |
| sysclk_en | output | 1 | System clock enable |
| bus_rst_req | output | NPORTS | One-cycle bus-reset request for each port |
| pwr_en | output | 1 | Enable of the powered domain (cable-not-active detection is not in it) |
| long_pend | output | 1 | 1 while the long reset width applies |

## Verification
The bench applies pairs of reset pulses that bracket each threshold: LONG_CYC-1 against LONG_CYC after power-on, and SHORT_CYC-1 against SHORT_CYC in normal operation. Each pair shows whether the right minimum width is chosen, and whether it is counted inclusively. It applies a power-down one cycle short of PD_CYC and a power-down of exactly PD_CYC, which separates an invalid power-down from one that re-arms the long width. It also holds the reset pin low through a power-down and releases it LONG_CYC-1 cycles later, which shows that low time during power-down is discarded. Several port_active masks are used across the releases, which shows that the bus-reset pulse follows the mask sampled at release.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic int_rst;
    logic clk_en;
    logic pwr_en;
    logic long_pend;
  } psq_stat_t;

  localparam psq_stat_t STAT_RESET = '{int_rst: 1'b1, clk_en: 1'b0,
                                       pwr_en: 1'b1, long_pend: 1'b1};
endpackage

// File: rtl/psq_rst_sync.sv
module psq_rst_sync #(
  parameter int unsigned STAGES = psq_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/psq_sat_cnt.sv
module psq_sat_cnt #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (!run)             cnt_d = '0;
    else if (cnt == LIM)  cnt_d = cnt;
    else                  cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 250000,
  parameter int unsigned SHORT_CYC = 1250,
  parameter int unsigned PD_CYC    = 187500,
  parameter int unsigned NPORTS    = 2,
  localparam int unsigned LW = $clog2(LONG_CYC + 1),
  localparam int unsigned PW = $clog2(PD_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin_n,
  input  logic              pwr_dn,
  input  logic [NPORTS-1:0] port_active,
  input  logic [LW-1:0]     lo_cnt,
  input  logic [PW-1:0]     pd_cnt,
  output psq_stat_t         stat,
  output logic [NPORTS-1:0] bus_pulse
);
  localparam logic [LW-1:0] LONG_V   = LW'(LONG_CYC);
  localparam logic [LW-1:0] SHORT_V  = LW'(SHORT_CYC);
  localparam logic [LW-1:0] LONG_M1  = LW'(LONG_CYC - 1);
  localparam logic [LW-1:0] SHORT_M1 = LW'(SHORT_CYC - 1);
  localparam logic [PW-1:0] PD_M1    = PW'(PD_CYC - 1);

  psq_stat_t         stat_d;
  logic [NPORTS-1:0] bus_d;
  logic [LW-1:0]     need, need_m1;
  logic              pin_low, reach, release_ev, pd_valid;

  always_comb begin
    need       = stat.long_pend ? LONG_V  : SHORT_V;
    need_m1    = stat.long_pend ? LONG_M1 : SHORT_M1;
    pin_low    = !rst_pin_n && !pwr_dn;
    reach      = pin_low && (lo_cnt >= need_m1);
    release_ev = rst_pin_n && !pwr_dn && (lo_cnt >= need);
    pd_valid   = pwr_dn && (pd_cnt >= PD_M1);

    stat_d.int_rst   = pwr_dn || reach || (stat.int_rst && !release_ev);
    stat_d.clk_en    = !stat.int_rst && !stat_d.int_rst;
    stat_d.pwr_en    = !pwr_dn;
    stat_d.long_pend = pd_valid || (stat.long_pend && !release_ev);
    bus_d            = release_ev ? port_active : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat      <= STAT_RESET;
      bus_pulse <= '0;
    end else begin
      stat      <= stat_d;
      bus_pulse <= bus_d;
    end
  end
endmodule

// File: rtl/phy_rst_pwr_seq.sv
module phy_rst_pwr_seq
  import psq_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 250000,
  parameter int unsigned SHORT_CYC = 1250,
  parameter int unsigned PD_CYC    = 187500,
  parameter int unsigned NPORTS    = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              pwr_dn,
  input  logic [NPORTS-1:0] port_active,
  output logic              int_rst,
  output logic              sysclk_en,
  output logic [NPORTS-1:0] bus_rst_req,
  output logic              pwr_en,
  output logic              long_pend
);
  localparam int unsigned LW = $clog2(LONG_CYC + 1);
  localparam int unsigned PW = $clog2(PD_CYC + 1);

  logic          rst_sync_n;
  logic [LW-1:0] lo_cnt;
  logic [PW-1:0] pd_cnt;
  psq_stat_t     stat;

  psq_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .arst_n(por_n), .rst_n_s(rst_sync_n)
  );

  psq_sat_cnt #(.LIMIT(LONG_CYC)) i_lo_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(!rst_pin_n && !pwr_dn), .cnt(lo_cnt)
  );

  psq_sat_cnt #(.LIMIT(PD_CYC)) i_pd_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(pwr_dn), .cnt(pd_cnt)
  );

  psq_ctrl #(
    .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .PD_CYC(PD_CYC), .NPORTS(NPORTS)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .rst_pin_n(rst_pin_n), .pwr_dn(pwr_dn),
    .port_active(port_active), .lo_cnt(lo_cnt), .pd_cnt(pd_cnt),
    .stat(stat), .bus_pulse(bus_rst_req)
  );

  assign int_rst   = stat.int_rst;
  assign sysclk_en = stat.clk_en;
  assign pwr_en    = stat.pwr_en;
  assign long_pend = stat.long_pend;
endmodule

// File: rtl/psq_chk.sv
module psq_chk #(
  parameter int unsigned NPORTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic [NPORTS-1:0] port_active,
  input logic              int_rst,
  input logic              sysclk_en,
  input logic [NPORTS-1:0] bus_rst_req,
  input logic              pwr_en,
  input logic              long_pend
);
  p_clk_off_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> !sysclk_en);
  p_clk_after_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |=> sysclk_en);
  p_pd_forces_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> int_rst);
  p_pwr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !pwr_en);
  p_pwr_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn |=> pwr_en);
  p_bus_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_rst_req) |=> !(|bus_rst_req));
  p_bus_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_rst_req) |-> ((bus_rst_req & ~$past(port_active)) == '0));
  p_bus_only_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_rst_req) |-> $fell(int_rst));
  p_long_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(long_pend) |-> $fell(int_rst));
  p_long_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_pend) |-> $past(pwr_dn));
endmodule

bind phy_rst_pwr_seq psq_chk #(.NPORTS(NPORTS)) u_psq_chk (
  .clk(clk), .rst_n(rst_sync_n), .pwr_dn(pwr_dn), .port_active(port_active),
  .int_rst(int_rst), .sysclk_en(sysclk_en), .bus_rst_req(bus_rst_req),
  .pwr_en(pwr_en), .long_pend(long_pend)
);

// File: tb/test_phy_rst_pwr_seq.sv
`timescale 1ns/1ps
module test_phy_rst_pwr_seq;
  localparam int LONG = 40;
  localparam int SHORT = 8;
  localparam int PD = 30;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic por_n, rst_pin_n, pwr_dn;
  logic [NP-1:0] port_active;
  logic int_rst, sysclk_en, pwr_en, long_pend;
  logic [NP-1:0] bus_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_rst_pwr_seq #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .PD_CYC(PD), .NPORTS(NP))
    i_phy_rst_pwr_seq (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .pwr_dn(pwr_dn),
      .port_active(port_active), .int_rst(int_rst), .sysclk_en(sysclk_en),
      .bus_rst_req(bus_rst_req), .pwr_en(pwr_en), .long_pend(long_pend));

  // behavioural reference
  int m_lo, m_pd, m_sync;
  bit m_irst, m_clk, m_pwr, m_long;
  logic [NP-1:0] m_bus;

  always @(posedge clk or negedge por_n) begin
    int need;
    bit grow, rel, pdv, nrst;
    if (!por_n) begin
      m_sync = 0; m_lo = 0; m_pd = 0; m_irst = 1; m_clk = 0;
      m_pwr = 1; m_long = 1; m_bus = '0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      need = m_long ? LONG : SHORT;
      grow = (rst_pin_n == 1'b0) && !pwr_dn && (m_lo + 1 >= need);
      rel  = rst_pin_n && !pwr_dn && (m_lo >= need);
      pdv  = pwr_dn && (m_pd + 1 >= PD);
      nrst = pwr_dn || grow || (m_irst && !rel);
      m_clk  = !m_irst && !nrst;
      m_long = pdv || (m_long && !rel);
      m_bus  = rel ? port_active : '0;
      m_pwr  = !pwr_dn;
      m_lo   = (!rst_pin_n && !pwr_dn) ? m_lo + 1 : 0;
      m_pd   = pwr_dn ? m_pd + 1 : 0;
      m_irst = nrst;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (por_n && !done) begin
      chk("R2/R3/R6 int_rst", int_rst, m_irst);
      chk("R5 sysclk_en", sysclk_en, m_clk);
      chk("R7 pwr_en", pwr_en, m_pwr);
      chk("R8/R9 long_pend", long_pend, m_long);
      checks++;
      if (bus_rst_req !== m_bus) begin
        errors++;
        $display("FAIL R4 bus_rst_req: actual %b expected %b at %0t",
                 bus_rst_req, m_bus, $time);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_low(int n);
    rst_pin_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b1; pwr_dn = 1'b0; port_active = 2'b01;
    idle(3);
    chk("R1 int_rst", int_rst, 1'b1);
    chk("R1 sysclk_en", sysclk_en, 1'b0);
    chk("R1 long_pend", long_pend, 1'b1);
    chk("R1 pwr_en", pwr_en, 1'b1);
    chk("R1 bus_rst_req", |bus_rst_req, 1'b0);
    por_n = 1'b1;
    idle(5);
    // R2: long width required after power-on
    pulse_low(LONG - 1); idle(5);
    chk("R2 short of long width", int_rst, 1'b1);
    pulse_low(LONG); idle(5);
    chk("R2 long width released", int_rst, 1'b0);
    chk("R9 long_pend cleared", long_pend, 1'b0);
    chk("R5 clock on", sysclk_en, 1'b1);
    // R3: short width in normal operation
    port_active = 2'b11;
    pulse_low(SHORT - 1); idle(5);
    chk("R3 short pulse ignored", int_rst, 1'b0);
    chk("R3 clock kept", sysclk_en, 1'b1);
    rst_pin_n = 1'b0;
    idle(SHORT);
    chk("R3 reset entered", int_rst, 1'b1);
    rst_pin_n = 1'b1;
    idle(5);
    chk("R3 reset released", int_rst, 1'b0);
    // R6/R7/R8: invalid power-down
    port_active = 2'b10;
    pwr_dn = 1'b1;
    idle(2);
    chk("R6 forced reset", int_rst, 1'b1);
    chk("R7 power off", pwr_en, 1'b0);
    idle(PD - 3);
    pwr_dn = 1'b0;
    idle(5);
    chk("R8 short power-down", long_pend, 1'b0);
    chk("R6 reset held", int_rst, 1'b1);
    pulse_low(SHORT); idle(5);
    chk("R3 released after short pd", int_rst, 1'b0);
    // R8/R10: valid power-down, low time during it discarded
    port_active = 2'b01;
    pwr_dn = 1'b1; rst_pin_n = 1'b0;
    idle(PD);
    pwr_dn = 1'b0;
    idle(2);
    chk("R8 valid power-down", long_pend, 1'b1);
    idle(LONG - 3);
    rst_pin_n = 1'b1;
    idle(5);
    chk("R10 count restarted", int_rst, 1'b1);
    pulse_low(LONG); idle(5);
    chk("R10 long reset after pd", int_rst, 1'b0);
    chk("R9 long_pend cleared again", long_pend, 1'b0);
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule